// File: doc/BRIEF.md
# FIFO-Fed I2S Frame Generator

This block turns a byte-wide external FIFO into a continuous stereo I2S stream of 16-bit samples. A free-running divider and a 64-slot frame counter, both clocked by the audio master clock, set all timing. Serial clock (SCK) is the master clock divided by four, so one stereo frame is 64 SCK periods and 256 master-clock cycles. With an 11.2896 MHz master clock this gives 44.1 kHz frames.

Late in the right half of each frame the block pulls four bytes from the FIFO with an active-low read strobe. The bytes arrive in the order left-low, left-high, right-low, right-high, which is the interleaved little-endian order of stereo PCM files. The bytes go into holding registers and are sent in the next frame. If the FIFO reports empty at the moment the block decides to fetch, the whole pair is replaced by zeros and the clocks keep running. A downstream DAC then hears silence and never sees a broken stream. All three I2S lines and the strobe come straight from flip-flops.

Slots are numbered 0 to 63 within a frame. A slot is four master-clock cycles long.

Top module: `fifo_i2s_gen`

## Requirements
- R1: While reset is held, rd_n is 1 and sck, lrck and sd are 0. After reset is released the frame starts at slot 0.
- R2: sck is 0 for the first two master-clock cycles of each slot and 1 for the last two. Every frame therefore has 64 sck periods.
- R3: lrck is 0 during slots 0–31 (left) and 1 during slots 32–63 (right). It changes only at a falling edge of sck.
- R4: sd carries the left sample MSB-first in slots 1–16 (bit 15 in slot 1) and the right sample MSB-first in slots 33–48. It is 0 in every other slot. sd changes only at a falling edge of sck.
- R5: rd_n is low for exactly the last two master-clock cycles of slots 44, 46, 48 and 50, and is high at all other times.
- R6: The FIFO ready state (fifo_empty = 0) is sampled once per frame, at the end of the first master-clock cycle of slot 44. That one decision sets whether all four strobes of the frame are issued. A change of fifo_empty later in the frame has no effect on that frame.
- R7: The bytes fetched in slots 44, 46, 48 and 50 are, in that order, left bits 7:0, left bits 15:8, right bits 7:0 and right bits 15:8.
- R8: When fifo_empty was 1 at the sampling point, no strobe is issued and the pair sent in the next frame is zero on both channels, while sck and lrck continue unchanged.
- R9: A pair fetched in frame N is sent in frame N+1. The samples being sent never change within a frame. The frame after reset sends zeros.
- R10: Each byte is taken from fifo_data at the master-clock edge at which rd_n returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio master clock (4 × sck) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_data | input | 8 | Byte presented by the FIFO while rd_n is low |
| fifo_empty | input | 1 | FIFO has no data (1) or is ready (0) |
| rd_n | output | 1 | Active-low FIFO read strobe |
| sck | output | 1 | I2S bit clock |
| lrck | output | 1 | I2S word select, 0 = left |
| sd | output | 1 | I2S serial data, MSB first |

## Verification
The assertions depend only on the block's own timing. They assume nothing about the FIFO except that fifo_empty and fifo_data hold still around each master-clock edge. The data checks assume that a FIFO reporting ready at slot 44 holds at least four bytes, and that it presents its head byte for the whole strobe and advances on the rising edge of rd_n. The stimulus drives inputs only on falling master-clock edges and writes the FIFO model in whole four-byte pairs. It forces fifo_empty high only as a deliberate starvation window, including windows that open or close just around the slot-44 sampling point.

// File: rtl/fifo_i2s_gen.sv
module fifo_i2s_gen #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              rd_n,
  output logic              sck,
  output logic              lrck,
  output logic              sd
);
  localparam int SMP_W   = 2 * BYTE_W;
  localparam int SLOTS   = 64;
  localparam int HALF    = SLOTS / 2;
  localparam int FETCH0  = 44;
  localparam int NBYTES  = 4;
  localparam int FETCHN  = FETCH0 + 2 * (NBYTES - 1);

  logic [1:0]        div;
  logic [5:0]        slot;
  logic              go;
  logic [BYTE_W-1:0] hold [NBYTES];
  logic [SMP_W-1:0]  left_q, right_q;
  logic              sd_next;

  wire        slot_end   = (div == 2'd3);
  wire [5:0]  nslot      = slot + 6'd1;
  wire        fetch_slot = !slot[0] && (slot >= 6'(FETCH0)) && (slot <= 6'(FETCHN));
  wire [5:0]  fetch_off  = slot - 6'(FETCH0);
  wire [1:0]  bsel       = fetch_off[2:1];
  wire [5:0]  loff       = nslot - 6'd1;
  wire [5:0]  roff       = nslot - 6'(HALF + 1);

  always_comb begin
    sd_next = 1'b0;
    if (nslot >= 6'd1 && nslot <= 6'(SMP_W))
      sd_next = left_q[4'(SMP_W - 1 - int'(loff))];
    else if (nslot >= 6'(HALF + 1) && nslot <= 6'(HALF + SMP_W))
      sd_next = right_q[4'(SMP_W - 1 - int'(roff))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      slot    <= '0;
      go      <= 1'b0;
      rd_n    <= 1'b1;
      sck     <= 1'b0;
      lrck    <= 1'b0;
      sd      <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      for (int i = 0; i < NBYTES; i++) hold[i] <= '0;
    end else begin
      div  <= div + 2'd1;
      sck  <= (div == 2'd1) || (div == 2'd2);
      rd_n <= !(go && fetch_slot && ((div == 2'd1) || (div == 2'd2)));
      if (div == 2'd0 && slot == 6'(FETCH0))
        go <= !fifo_empty;
      if (slot_end) begin
        slot <= nslot;
        lrck <= nslot[5];
        sd   <= sd_next;
        if (fetch_slot)
          hold[bsel] <= go ? fifo_data : '0;
        if (slot == 6'(SLOTS - 1)) begin
          left_q  <= {hold[1], hold[0]};
          right_q <= {hold[3], hold[2]};
        end
      end
    end
  end
endmodule

module fifo_i2s_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic sck,
  input logic lrck,
  input logic sd
);
  AST_SCK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |=> sck); // R2
  AST_SCK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n) $fell(sck) |=> !sck); // R2
  AST_LRCK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(lrck) |-> $fell(sck)); // R3
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sd) |-> $fell(sck)); // R4
  AST_STROBE_IN_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> sck); // R5
  AST_STROBE_RIGHT_HALF: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> lrck); // R5
  AST_STROBE_TWO_WIDE: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_n) |=> !rd_n); // R5
  AST_STROBE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && $past(!rd_n)) |=> rd_n); // R5
endmodule

bind fifo_i2s_gen fifo_i2s_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .sck(sck), .lrck(lrck), .sd(sd)
);

// File: tb/tb_fifo_i2s_gen.sv
module tb_fifo_i2s_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       starve = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_empty;
  logic       rd_n, sck, lrck, sd;

  int compared = 0;
  int mismatched = 0;
  logic done = 1'b0;

  logic [7:0] mem [0:4095];
  int wp = 0, rp = 0;

  always #2 clk = ~clk;

  assign fifo_data  = mem[rp[11:0]];
  assign fifo_empty = starve || (wp == rp);

  always @(posedge rd_n) if (rst_n && wp != rp) rp = rp + 1;

  fifo_i2s_gen dut (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .rd_n(rd_n), .sck(sck), .lrck(lrck), .sd(sd)
  );

  // behavioural reference: absolute edge count since reset
  int t = 0, mp = 0;
  logic mgo = 1'b0;
  logic [7:0] sh [4];
  logic [15:0] cl = '0, cr = '0;

  function automatic logic is_fetch(int s);
    return (s == 44) || (s == 46) || (s == 48) || (s == 50);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      t = 0; mp = 0; mgo = 1'b0; cl = '0; cr = '0;
      for (int i = 0; i < 4; i++) sh[i] = '0;
    end else begin
      int bd, bs;
      bd = t % 4;
      bs = (t / 4) % 64;
      if (t % 256 == 176) mgo = !fifo_empty;           // R6
      if (bd == 3 && is_fetch(bs)) begin               // R7 R10
        if (mgo) begin sh[(bs - 44) / 2] = mem[mp[11:0]]; mp = mp + 1; end
        else sh[(bs - 44) / 2] = '0;                   // R8
      end
      if (bd == 3 && bs == 63) begin                   // R9
        cl = {sh[1], sh[0]};
        cr = {sh[3], sh[2]};
      end
      t = t + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at edge %0d: actual %b expected %b", tag, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, s;
      logic e_sd;
      a = t;
      s = (a / 4) % 64;
      e_sd = 1'b0;
      if (s >= 1 && s <= 16) e_sd = cl[16 - s];
      else if (s >= 33 && s <= 48) e_sd = cr[48 - s];
      check("R2 sck", sck, (a % 4) >= 2);
      check("R3 lrck", lrck, s >= 32);
      check("R4/R7/R8/R9/R10 sd", sd, e_sd);
      check("R5/R6 rd_n", rd_n, !(mgo && is_fetch(s) && (a % 4) >= 2));
    end
  end

  task automatic push_pair(input logic [15:0] l, input logic [15:0] r);
    mem[wp[11:0]] = l[7:0];      wp = wp + 1;
    mem[wp[11:0]] = l[15:8];     wp = wp + 1;
    mem[wp[11:0]] = r[7:0];      wp = wp + 1;
    mem[wp[11:0]] = r[15:8];     wp = wp + 1;
  endtask

  task automatic frames(input int n);
    repeat (n * 256) @(negedge clk);
  endtask

  task automatic wait_phase(input int ph);
    @(negedge clk);
    while (t % 256 != ph) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (6) @(negedge clk);
    check("R1 rd_n", rd_n, 1'b1);
    check("R1 sck", sck, 1'b0);
    check("R1 lrck", lrck, 1'b0);
    check("R1 sd", sd, 1'b0);
    rst_n = 1'b1;
    // boundary patterns, then drain into underrun (R8)
    push_pair(16'h8001, 16'h7FFE);
    push_pair(16'hA55A, 16'h5AA5);
    push_pair(16'hFFFF, 16'h0000);
    frames(6);
    // computed patterns
    for (int i = 0; i < 4; i++)
      push_pair(16'((i * 40503 + 4660) & 16'hFFFF), 16'((i * 9973 + 291) & 16'hFFFF));
    frames(5);
    // R6: empty at sampling, ready shortly after -> whole pair skipped
    push_pair(16'h1234, 16'hFEDC);
    push_pair(16'h0F0F, 16'hC3C3);
    wait_phase(170);
    starve = 1'b1;
    wait_phase(190);
    starve = 1'b0;
    frames(3);
    // R6: ready at sampling, empty right after -> all four bytes still read
    push_pair(16'h4321, 16'h8765);
    wait_phase(180);
    starve = 1'b1;
    wait_phase(210);
    starve = 1'b0;
    frames(3);
    compared++;
    if (rp != mp || wp != rp) begin
      mismatched++;
      $display("FAIL R6 bytes consumed: actual %0d expected %0d (written %0d)", rp, mp, wp);
    end
    finish_run();
  end
endmodule